// File: doc/BRIEF.md
# Single-Slot Monitor Channel FIFO

This block links one timeslot of a serial time-division frame to a microprocessor register bus through two small byte queues. The processor writes the number of the timeslot that faces the wanted subscriber. In every frame, the block collects the eight bits received in that slot into a receive queue. In the same slot it sends the next byte taken from a transmit queue. Only one slot is served at a time. The slot must be even, because the odd slot that follows it carries the paired control channel and is never touched here.

The serial side is driven by a single system clock. A one-cycle bit strobe stands for each bit time, and a frame sync input marks the first bit of a frame. Bytes pass through unchanged, or they are complemented in both directions when the mode register asks for that simple preprocessing step. Software sees five byte-wide registers: transmit data, receive data, status, slot number and mode.

Top module: `mon_slot_fifo`

## Requirements
- R1: After reset both queues are empty, the slot number reads 0, the mode reads 0, the overflow bit is 0, and ser_out is 1.
- R2: A write to the slot register (address 3, slot number in the low bits) is accepted only when bit 0 of the data is 0. An odd write leaves the slot number and both queues unchanged.
- R3: An accepted slot write empties both queues in the same cycle. Bytes that were pending are never sent or read.
- R4: Bit time n after frame sync (the sync strobe is time 0) belongs to slot n/8, most significant bit first. The byte received in the selected slot is appended to the receive queue, and reads of address 1 return the bytes oldest first, each read removing one.
- R5: At the strobe of bit time n, ser_out takes the value of bit n and holds it until the next strobe. Outside the selected slot that value is 1.
- R6: If the transmit queue is empty when the selected slot begins, the slot carries 0xFF.
- R7: A byte received while the receive queue holds 8 bytes is dropped and sets a sticky overflow flag (status bit 4). Writing status with bit 4 set clears the flag.
- R8: The transmit queue holds 8 bytes. A write to address 0 while it is full is ignored.
- R9: With mode bit 0 set, transmitted queue bytes and received bytes are complemented. The 0xFF fill is not affected.
- R10: Status (address 2) reads bit 0 tx empty, bit 1 tx full, bit 2 rx empty, bit 3 rx full, bit 4 overflow, and the upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe per serial bit time |
| fsync | input | 1 | Frame start, valid together with bit_stb |
| ser_in | input | 1 | Serial receive data, sampled at bit_stb |
| ser_out | output | 1 | Serial transmit data, updated at bit_stb |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (removes a receive byte at address 1) |
| bus_rdata | output | 8 | Register read data, combinational from bus_addr |

## Verification
The hardest state to reach is a full receive queue with a ninth byte arriving, because only one byte enters per frame. The bench runs nine whole frames without reading, then checks the flag. It also drains all eight bytes to show that the ninth was dropped. A second hard case is a slot change with bytes still pending in both queues. The bench sets this up by queuing transmit bytes and letting one frame deliver a received byte just before it moves the slot. The next frame on the new slot must then carry only the fill value.

// File: rtl/msf_pkg.sv
package msf_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BUS_AW = 3;

  localparam logic [BUS_AW-1:0] ADR_TXDATA = 3'd0;
  localparam logic [BUS_AW-1:0] ADR_RXDATA = 3'd1;
  localparam logic [BUS_AW-1:0] ADR_STATUS = 3'd2;
  localparam logic [BUS_AW-1:0] ADR_SLOT   = 3'd3;
  localparam logic [BUS_AW-1:0] ADR_MODE   = 3'd4;

  localparam int unsigned ST_TX_EMPTY = 0;
  localparam int unsigned ST_TX_FULL  = 1;
  localparam int unsigned ST_RX_EMPTY = 2;
  localparam int unsigned ST_RX_FULL  = 3;
  localparam int unsigned ST_RX_OVF   = 4;

  typedef struct packed {
    logic tx_empty;
    logic tx_full;
    logic rx_empty;
    logic rx_full;
  } q_flags_t;
endpackage

// File: rtl/msf_byte_fifo.sv
module msf_byte_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_n, rd_ptr_q, rd_ptr_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem_q[rd_ptr_q];

  always_comb begin
    wr_ptr_n = wr_ptr_q;
    rd_ptr_n = rd_ptr_q;
    cnt_n    = cnt_q;
    if (flush) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      cnt_n    = '0;
    end else begin
      if (push_ok) wr_ptr_n = ptr_step(wr_ptr_q);
      if (pop_ok)  rd_ptr_n = ptr_step(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_n = cnt_q + CNT_W'(1);
        2'b01:   cnt_n = cnt_q - CNT_W'(1);
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      cnt_q    <= cnt_n;
    end
  end

  // storage carries no reset; only the pointers define validity
  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem_q[wr_ptr_q] <= push_data;
  end

  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  assert_full_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (full && $stable(cnt_q)));
endmodule

// File: rtl/msf_slot_port.sv
module msf_slot_port #(
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              fsync,
  input  logic              ser_in,
  input  logic [SLOT_W-1:0] slot_sel,
  input  logic              invert,
  input  logic [7:0]        tx_head,
  input  logic              tx_avail,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [7:0]        rx_byte,
  output logic              ser_out
);
  localparam int unsigned FRAME_BITS = NUM_SLOTS * 8;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);

  logic [CNT_W-1:0] bit_cnt_q, bit_cnt_n, cur_idx;
  logic [7:0]       tx_sh_q, tx_sh_n, rx_sh_q, rx_sh_n, tx_load;
  logic             ser_out_q, ser_out_n;
  logic             in_frame, slot_hit;
  logic [2:0]       phase;

  assign cur_idx  = fsync ? '0 : bit_cnt_q;
  assign in_frame = (cur_idx < CNT_W'(FRAME_BITS));
  assign slot_hit = bit_stb && in_frame && ((cur_idx >> 3) == CNT_W'(slot_sel));
  assign phase    = cur_idx[2:0];
  assign tx_load  = tx_avail ? (tx_head ^ {8{invert}}) : 8'hFF;
  assign ser_out  = ser_out_q;

  always_comb begin
    bit_cnt_n = bit_cnt_q;
    tx_sh_n   = tx_sh_q;
    rx_sh_n   = rx_sh_q;
    ser_out_n = ser_out_q;
    tx_pop    = 1'b0;
    rx_push   = 1'b0;
    rx_byte   = {rx_sh_q[6:0], ser_in} ^ {8{invert}};
    if (bit_stb) begin
      bit_cnt_n = in_frame ? cur_idx + CNT_W'(1) : cur_idx;
      if (slot_hit) begin
        rx_sh_n = {rx_sh_q[6:0], ser_in};
        if (phase == 3'd0) begin
          ser_out_n = tx_load[7];
          tx_sh_n   = {tx_load[6:0], 1'b0};
          tx_pop    = tx_avail;
        end else begin
          ser_out_n = tx_sh_q[7];
          tx_sh_n   = {tx_sh_q[6:0], 1'b0};
        end
        rx_push = (phase == 3'd7);
      end else begin
        ser_out_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= CNT_W'(FRAME_BITS);
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      ser_out_q <= 1'b1;
    end else begin
      bit_cnt_q <= bit_cnt_n;
      tx_sh_q   <= tx_sh_n;
      rx_sh_q   <= rx_sh_n;
      ser_out_q <= ser_out_n;
    end
  end

  assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !slot_hit) |=> ser_out);

  assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(ser_out));

  assert_empty_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_hit && phase == 3'd0 && !tx_avail) |=> ser_out);
endmodule

// File: rtl/mon_slot_fifo.sv
module mon_slot_fifo
  import msf_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = 32,
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       fsync,
  input  logic       ser_in,
  output logic       ser_out,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_wr,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata
);
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS);

  logic [SLOT_W-1:0] slot_q, slot_n;
  logic              invert_q, invert_n;
  logic              ovf_q, ovf_n;
  logic              slot_wr, slot_ok, flush, ovf_clr;
  logic              tx_push, rx_pop, tx_pop, rx_push;
  logic [7:0]        tx_head, rx_head, rx_byte;
  q_flags_t          flg;

  assign slot_wr = bus_wr && (bus_addr == ADR_SLOT);
  assign slot_ok = slot_wr && !bus_wdata[0];
  assign flush   = slot_ok;
  assign ovf_clr = bus_wr && (bus_addr == ADR_STATUS) && bus_wdata[ST_RX_OVF];
  assign tx_push = bus_wr && (bus_addr == ADR_TXDATA);
  assign rx_pop  = bus_rd && (bus_addr == ADR_RXDATA);

  msf_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_tx_q (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(tx_push), .push_data(bus_wdata), .pop(tx_pop),
    .head(tx_head), .full(flg.tx_full), .empty(flg.tx_empty)
  );

  msf_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_rx_q (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_push), .push_data(rx_byte), .pop(rx_pop),
    .head(rx_head), .full(flg.rx_full), .empty(flg.rx_empty)
  );

  msf_slot_port #(.NUM_SLOTS(NUM_SLOTS)) u_port (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .fsync(fsync), .ser_in(ser_in),
    .slot_sel(slot_q), .invert(invert_q), .tx_head(tx_head), .tx_avail(!flg.tx_empty),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte), .ser_out(ser_out)
  );

  always_comb begin
    slot_n   = slot_q;
    invert_n = invert_q;
    ovf_n    = ovf_q;
    if (slot_ok) slot_n = bus_wdata[SLOT_W-1:0];
    if (bus_wr && (bus_addr == ADR_MODE)) invert_n = bus_wdata[0];
    if (ovf_clr) ovf_n = 1'b0;
    if (rx_push && flg.rx_full && !flush) ovf_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= '0;
      invert_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      slot_q   <= slot_n;
      invert_q <= invert_n;
      ovf_q    <= ovf_n;
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_RXDATA: bus_rdata = rx_head;
      ADR_STATUS: bus_rdata = {3'b000, ovf_q, flg.rx_full, flg.rx_empty, flg.tx_full, flg.tx_empty};
      ADR_SLOT:   bus_rdata = 8'(slot_q);
      ADR_MODE:   bus_rdata = {7'b0, invert_q};
      default:    bus_rdata = 8'h00;
    endcase
  end

  assert_slot_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q[0] == 1'b0);

  assert_odd_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_wr && bus_wdata[0]) |=> $stable(slot_q));

  assert_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_ok |=> (flg.tx_empty && flg.rx_empty));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
endmodule

// File: tb/test_mon_slot_fifo.sv
module test_mon_slot_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT      = 32;
  localparam int FBITS      = NSLOT * 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_stb = 1'b0, fsync = 1'b0, ser_in = 1'b0;
  logic       ser_out;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] tx_exp_q[$];
  logic [7:0] rx_exp_q[$];
  bit inv_model = 1'b0;
  bit ovf_model = 1'b0;
  int cur_slot = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mon_slot_fifo i_mon_slot_fifo (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .fsync(fsync), .ser_in(ser_in),
    .ser_out(ser_out), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = (a == 3'd1);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // driver: tx bytes go to the scoreboard only if the 8-entry queue has room (R8)
  task automatic send_tx(input logic [7:0] b);
    bus_write(3'd0, b);
    if (tx_exp_q.size() < 8) tx_exp_q.push_back(b);
  endtask

  // one frame: drive rx byte in the selected slot, capture tx byte, compare
  task automatic run_frame(input logic [7:0] rx_val, input string req);
    logic [7:0] cap = '0;
    logic [7:0] exp;
    bit idle_ok = 1'b1;
    for (int k = 0; k < FBITS; k++) begin
      @(negedge clk);
      bit_stb = 1'b1; fsync = (k == 0);
      ser_in = (k / 8 == cur_slot) ? rx_val[7 - (k % 8)] : k[1];
      @(negedge clk);
      bit_stb = 1'b0; fsync = 1'b0;
      if (k / 8 == cur_slot) cap[7 - (k % 8)] = ser_out;
      else if (ser_out !== 1'b1) idle_ok = 1'b0;
    end
    if (tx_exp_q.size() > 0) exp = tx_exp_q.pop_front() ^ {8{inv_model}};
    else exp = 8'hFF;
    chk({req, " tx slot byte"}, cap, exp);
    chk("R5 idle ones outside slot", 8'(idle_ok), 8'd1);
    if (rx_exp_q.size() < 8) rx_exp_q.push_back(rx_val ^ {8{inv_model}});
    else ovf_model = 1'b1;
  endtask

  // monitor side of the rx scoreboard
  task automatic drain_rx(input string req);
    logic [7:0] d;
    while (rx_exp_q.size() > 0) begin
      bus_read(3'd1, d);
      chk(req, d, rx_exp_q.pop_front());
    end
  endtask

  function automatic logic [7:0] stat_model();
    int tn = tx_exp_q.size();
    int rn = rx_exp_q.size();
    return {3'b000, ovf_model, rn == 8, rn == 0, tn == 8, tn == 0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R10 reset state
    #1 chk("R1 ser_out idle after reset", 8'(ser_out), 8'd1);
    bus_read(3'd2, d); chk("R1 R10 status after reset", d, 8'h05);
    bus_read(3'd3, d); chk("R1 slot after reset", d, 8'h00);
    bus_read(3'd4, d); chk("R1 mode after reset", d, 8'h00);

    // R2 slot select, odd write rejected
    bus_write(3'd3, 8'd4); cur_slot = 4;
    bus_read(3'd3, d); chk("R2 even slot accepted", d, 8'd4);
    bus_write(3'd3, 8'd7);
    bus_read(3'd3, d); chk("R2 odd slot rejected", d, 8'd4);

    // R4 R5 R6 basic exchange
    send_tx(8'hA1); send_tx(8'h5E); send_tx(8'h80);
    run_frame(8'h3C, "R5");
    run_frame(8'hC3, "R5");
    run_frame(8'h01, "R5");
    run_frame(8'hFE, "R6");
    bus_read(3'd2, d); chk("R10 status four rx bytes", d, stat_model());
    drain_rx("R4 rx byte order");

    // R8 transmit queue bound
    for (int i = 0; i < 10; i++) send_tx(8'h10 + 8'(i));
    bus_read(3'd2, d); chk("R8 R10 tx full status", d, stat_model());
    for (int i = 0; i < 9; i++) run_frame(8'(i * 17), "R8");
    drain_rx("R4 rx after tx burst");
    rx_exp_q.delete();

    // R7 receive overflow
    for (int i = 0; i < 9; i++) run_frame(8'h60 + 8'(i), "R6");
    bus_read(3'd2, d); chk("R7 R10 overflow and rx full", d, stat_model());
    drain_rx("R7 ninth byte dropped");
    bus_read(3'd2, d); chk("R7 overflow sticky after drain", d, stat_model());
    bus_write(3'd2, 8'h10); ovf_model = 1'b0;
    bus_read(3'd2, d); chk("R7 overflow cleared", d, stat_model());

    // R2 odd write keeps queue contents; R3 flush on accepted write
    send_tx(8'h77); send_tx(8'h88);
    run_frame(8'h99, "R5");
    bus_write(3'd3, 8'd9);
    bus_read(3'd2, d); chk("R2 odd write leaves queues", d, stat_model());
    bus_write(3'd3, 8'd6); cur_slot = 6;
    tx_exp_q.delete(); rx_exp_q.delete();
    bus_read(3'd2, d); chk("R3 flush empties both", d, 8'h05);
    run_frame(8'h42, "R3");
    drain_rx("R3 rx on new slot");

    // R9 inversion mode
    bus_write(3'd4, 8'h01); inv_model = 1'b1;
    send_tx(8'h3C);
    run_frame(8'hA5, "R9");
    run_frame(8'h0F, "R9");
    drain_rx("R9 inverted rx");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule